// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits inside a DDR SDRAM controller and takes care of programming the memory's two mode registers. A client hands it one request carrying the wanted burst length, burst ordering, CAS latency, DLL on/off choice and output drive strength. Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where both `req_valid` and `req_ready` are high. While a sequence runs, `req_ready` stays low and the client must hold or withdraw its request. Nothing is lost: the request fields are captured at acceptance.

A request that asks for a reserved burst length or CAS latency is refused with a one-cycle error pulse, and no command is issued. A legal request makes the sequencer wait until the controller reports every bank idle and no burst in flight. It then takes the command bus and issues two load-mode-register commands, each followed by a programmable quiet period. The first command writes the extended register, which holds the DLL and drive settings. The second writes the base register with burst and latency settings, and it carries the DLL-reset request whenever the DLL is being switched on. A done pulse hands the bus back.

Top module: `modereg_seq`

## Requirements
- R1: Out of reset and whenever no sequence runs, `req_ready` is 1 and `cmd_lmr_o`, `own_bus_o`, `done_o` and `err_o` are 0. While a sequence runs, `req_ready` is 0.
- R2: A request with `req_burst_len` not in {2,4,8} or `req_cas_half` not in {4,5} makes `err_o` pulse for exactly the one cycle after acceptance. No load command and no `done_o` follow, and `req_ready` stays 1.
- R3: No load command is issued while `banks_idle` is 0 or `burst_active` is 1. The first load appears in the cycle after the one in which both conditions first hold.
- R4: The first load of a sequence writes the extended register: `ba_o`=01, `addr_o[0]` = NOT `req_dll_en`, `addr_o[1]` = `req_drive_weak`, and all other address bits are 0.
- R5: The second load writes the base register: `ba_o`=00, and all address bits not listed here are 0. Burst length codes go in `addr_o[2:0]` (2→001, 4→010, 8→011). `addr_o[3]` is 1 for interleaved order. CAS latency codes go in `addr_o[6:4]` (2→010, 2.5→110). `addr_o[8]` = `req_dll_en`, which requests a DLL reset.
- R6: Each load is a one-cycle pulse followed by WAIT_CYC cycles with no command. The base-register load comes exactly WAIT_CYC+1 cycles after the extended-register load.
- R7: `done_o` pulses for one cycle, exactly WAIT_CYC+1 cycles after the base-register load. `req_ready` returns to 1 in the next cycle.
- R8: `own_bus_o` is 1 from the extended-register load through the end of the quiet period after the base-register load, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_burst_len | input | 4 | Burst length in beats (2, 4 or 8 legal) |
| req_interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| req_cas_half | input | 3 | CAS latency in half cycles (4 = 2, 5 = 2.5 legal) |
| req_dll_en | input | 1 | 1 = enable DLL (and reset it) |
| req_drive_weak | input | 1 | 1 = reduced output drive |
| banks_idle | input | 1 | All banks idle |
| burst_active | input | 1 | A burst is in progress |
| cmd_lmr_o | output | 1 | Load-mode-register command strobe |
| ba_o | output | BA_W (2) | Bank-select lines, choose the register |
| addr_o | output | ADDR_W (13) | Address lines carrying the register value |
| own_bus_o | output | 1 | Sequencer holds the command bus |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | One-cycle reserved-request pulse |

## Verification
The bench builds the block with WAIT_CYC set to 3 instead of the default 2. With that value, a quiet period that is one cycle short or one cycle long shows up as a wrong spacing between the two loads and the done pulse. ADDR_W stays at 13, so address bits above A8 are present and can be checked to be zero. The table walks sequential and interleaved orders, both latencies, all three burst lengths, both DLL choices and both drive strengths, plus reserved lengths and latencies. Directed cases then hold the bank-idle and burst inputs against the sequencer.

// File: rtl/modereg_pkg.sv
package modereg_pkg;
  // one-hot state bit positions
  localparam int S_IDLE      = 0;
  localparam int S_WAIT_IDLE = 1;
  localparam int S_LOAD_EMR  = 2;
  localparam int S_WAIT_EMR  = 3;
  localparam int S_LOAD_MR   = 4;
  localparam int S_WAIT_MR   = 5;
  localparam int S_DONE      = 6;
  localparam int NSTATE      = 7;

  localparam logic [2:0] BL_CODE_2  = 3'b001;
  localparam logic [2:0] BL_CODE_4  = 3'b010;
  localparam logic [2:0] BL_CODE_8  = 3'b011;
  localparam logic [2:0] CL_CODE_20 = 3'b010;
  localparam logic [2:0] CL_CODE_25 = 3'b110;

  typedef struct packed {
    logic       ok;
    logic [2:0] code;
  } field_code_t;

  function automatic field_code_t burst_code(input logic [3:0] beats);
    field_code_t r;
    r.ok = 1'b1;
    case (beats)
      4'd2:    r.code = BL_CODE_2;
      4'd4:    r.code = BL_CODE_4;
      4'd8:    r.code = BL_CODE_8;
      default: begin r.ok = 1'b0; r.code = 3'b000; end
    endcase
    return r;
  endfunction

  function automatic field_code_t latency_code(input logic [2:0] half_cyc);
    field_code_t r;
    r.ok = 1'b1;
    case (half_cyc)
      3'd4:    r.code = CL_CODE_20;
      3'd5:    r.code = CL_CODE_25;
      default: begin r.ok = 1'b0; r.code = 3'b000; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/modereg_encode.sv
module modereg_encode
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [3:0]        burst_len,
  input  logic              interleave,
  input  logic [2:0]        cas_half,
  input  logic              dll_en,
  input  logic              drive_weak,
  output logic              legal,
  output logic [ADDR_W-1:0] ext_word,
  output logic [ADDR_W-1:0] base_word
);
  field_code_t bl;
  field_code_t cl;

  always_comb begin
    bl    = burst_code(burst_len);
    cl    = latency_code(cas_half);
    legal = bl.ok & cl.ok;

    ext_word    = '0;
    ext_word[0] = ~dll_en;      // 0 keeps the DLL running
    ext_word[1] = drive_weak;

    base_word      = '0;
    base_word[2:0] = bl.code;
    base_word[3]   = interleave;
    base_word[6:4] = cl.code;
    base_word[8]   = dll_en;    // DLL reset operating mode
  end
endmodule

// File: rtl/modereg_wait_timer.sv
module modereg_wait_timer #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYC) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (!expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/modereg_fsm.sv
module modereg_fsm
  import modereg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic legal,
  input  logic bus_free,
  input  logic tmr_exp,
  output logic ready,
  output logic accept_ok,
  output logic load_ext,
  output logic load_base,
  output logic tmr_run,
  output logic own_bus,
  output logic done,
  output logic err
);
  logic [NSTATE-1:0] st_q, st_n;
  logic              accept;
  logic              err_q;

  assign ready     = st_q[S_IDLE];
  assign accept    = req_valid && ready;
  assign accept_ok = accept && legal;
  assign load_ext  = st_q[S_LOAD_EMR];
  assign load_base = st_q[S_LOAD_MR];
  assign tmr_run   = st_q[S_WAIT_EMR] | st_q[S_WAIT_MR];
  assign own_bus   = st_q[S_LOAD_EMR] | st_q[S_WAIT_EMR] |
                     st_q[S_LOAD_MR]  | st_q[S_WAIT_MR];
  assign done      = st_q[S_DONE];
  assign err       = err_q;

  always_comb begin
    st_n = '0;
    if (st_q[S_IDLE]) begin
      if (accept_ok) st_n[S_WAIT_IDLE] = 1'b1;
      else           st_n[S_IDLE]      = 1'b1;
    end
    if (st_q[S_WAIT_IDLE]) begin
      if (bus_free) st_n[S_LOAD_EMR]  = 1'b1;
      else          st_n[S_WAIT_IDLE] = 1'b1;
    end
    if (st_q[S_LOAD_EMR]) st_n[S_WAIT_EMR] = 1'b1;
    if (st_q[S_WAIT_EMR]) begin
      if (tmr_exp) st_n[S_LOAD_MR]  = 1'b1;
      else         st_n[S_WAIT_EMR] = 1'b1;
    end
    if (st_q[S_LOAD_MR]) st_n[S_WAIT_MR] = 1'b1;
    if (st_q[S_WAIT_MR]) begin
      if (tmr_exp) st_n[S_DONE]    = 1'b1;
      else         st_n[S_WAIT_MR] = 1'b1;
    end
    if (st_q[S_DONE]) st_n[S_IDLE] = 1'b1;
    // recover from a corrupted encoding
    if ($countones(st_n) != 1) begin
      st_n         = '0;
      st_n[S_IDLE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= '0;
      st_q[S_IDLE] <= 1'b1;
      err_q        <= 1'b0;
    end else begin
      st_q  <= st_n;
      err_q <= accept && !legal;
    end
  end
endmodule

// File: rtl/modereg_seq.sv
module modereg_seq #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_burst_len,
  input  logic              req_interleave,
  input  logic [2:0]        req_cas_half,
  input  logic              req_dll_en,
  input  logic              req_drive_weak,
  input  logic              banks_idle,
  input  logic              burst_active,
  output logic              cmd_lmr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              own_bus_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [BA_W-1:0] SEL_EXT  = BA_W'(1);
  localparam logic [BA_W-1:0] SEL_BASE = BA_W'(0);

  logic              legal;
  logic [ADDR_W-1:0] ext_w, base_w;
  logic [ADDR_W-1:0] ext_q, base_q;
  logic              accept_ok, load_ext, load_base;
  logic              tmr_run, tmr_exp;

  modereg_encode #(.ADDR_W(ADDR_W)) u_enc (
    .burst_len (req_burst_len),
    .interleave(req_interleave),
    .cas_half  (req_cas_half),
    .dll_en    (req_dll_en),
    .drive_weak(req_drive_weak),
    .legal     (legal),
    .ext_word  (ext_w),
    .base_word (base_w)
  );

  modereg_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .legal    (legal),
    .bus_free (banks_idle && !burst_active),
    .tmr_exp  (tmr_exp),
    .ready    (req_ready),
    .accept_ok(accept_ok),
    .load_ext (load_ext),
    .load_base(load_base),
    .tmr_run  (tmr_run),
    .own_bus  (own_bus_o),
    .done     (done_o),
    .err      (err_o)
  );

  modereg_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q  <= '0;
      base_q <= '0;
    end else if (accept_ok) begin
      ext_q  <= ext_w;
      base_q <= base_w;
    end
  end

  assign cmd_lmr_o = load_ext | load_base;
  assign ba_o      = load_ext ? SEL_EXT : SEL_BASE;
  assign addr_o    = load_ext ? ext_q : (load_base ? base_q : '0);
endmodule

// File: rtl/modereg_seq_chk.sv
module modereg_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int WAIT_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              banks_idle,
  input logic              burst_active,
  input logic              cmd_lmr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              own_bus_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int GAP_W = $clog2(WAIT_CYC + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(WAIT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(WAIT_CYC);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q, pend_q, ext_a0_q;
  logic             ext_load, base_load;

  assign ext_load  = cmd_lmr_o && (ba_o == BA_W'(1));
  assign base_load = cmd_lmr_o && (ba_o == BA_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      pend_q   <= 1'b0;
      ext_a0_q <= 1'b0;
    end else begin
      if (cmd_lmr_o)            gap_q <= '0;
      else if (gap_q < GAP_SAT) gap_q <= gap_q + 1'b1;
      if (cmd_lmr_o) seen_q <= 1'b1;
      if (ext_load) begin
        pend_q   <= 1'b1;
        ext_a0_q <= addr_o[0];
      end else if (base_load) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_lmr_o && !own_bus_o));

  assert_err_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!err_o && !cmd_lmr_o));

  assert_bank_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_load |-> $past(banks_idle && !burst_active));

  assert_ext_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |-> pend_q);

  assert_dll_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |-> (addr_o[8] == !ext_a0_q));

  assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lmr_o && seen_q) |-> (gap_q >= GAP_MIN));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && req_ready));

  assert_own_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lmr_o |-> own_bus_o);
endmodule

bind modereg_seq modereg_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYC(WAIT_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .banks_idle  (banks_idle),
  .burst_active(burst_active),
  .cmd_lmr_o   (cmd_lmr_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .own_bus_o   (own_bus_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/modereg_seq_bench.sv
`timescale 1ns/1ps
module modereg_seq_bench;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int WAIT   = 3;
  localparam int NVEC   = 8;

  // {len[36:33], ilv[32], cas_half[31:29], dll[28], weak[27], exp_err[26], ext[25:13], base[12:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd8, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 13'h000, 13'h163},
    {4'd4, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0, 13'h003, 13'h02A},
    {4'd2, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 13'h002, 13'h121},
    {4'd8, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 13'h001, 13'h06B},
    {4'd3, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 13'h000, 13'h000},
    {4'd4, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 13'h000, 13'h000},
    {4'd1, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 13'h000, 13'h000},
    {4'd4, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 13'h000, 13'h162}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_burst_len = '0;
  logic              req_interleave = 1'b0;
  logic [2:0]        req_cas_half = '0;
  logic              req_dll_en = 1'b0;
  logic              req_drive_weak = 1'b0;
  logic              banks_idle = 1'b1;
  logic              burst_active = 1'b0;
  logic              cmd_lmr_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic              own_bus_o, done_o, err_o;

  always #2.5 clk = ~clk;

  modereg_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYC(WAIT)) u_modereg_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_burst_len(req_burst_len), .req_interleave(req_interleave),
    .req_cas_half(req_cas_half), .req_dll_en(req_dll_en),
    .req_drive_weak(req_drive_weak), .banks_idle(banks_idle),
    .burst_active(burst_active), .cmd_lmr_o(cmd_lmr_o), .ba_o(ba_o),
    .addr_o(addr_o), .own_bus_o(own_bus_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  int n_lmr = 0, done_cnt = 0, done_cyc = 0, err_cnt = 0, err_cyc = 0;
  int log_ba [64];
  int log_addr [64];
  int log_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_lmr_o && n_lmr < 64) begin
        log_ba[n_lmr]   = int'(ba_o);
        log_addr[n_lmr] = int'(addr_o);
        log_cyc[n_lmr]  = cyc;
        n_lmr = n_lmr + 1;
      end
      if (done_o) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
      if (err_o)  begin err_cnt = err_cnt + 1;   err_cyc = cyc;  end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [36:0] v);
    while (!req_ready) @(negedge clk);
    req_burst_len  = v[36:33];
    req_interleave = v[32];
    req_cas_half   = v[31:29];
    req_dll_en     = v[28];
    req_drive_weak = v[27];
    req_valid      = 1'b1;
  endtask

  task automatic run_vec(input logic [36:0] v);
    int base, dbase, ebase, acc;
    offer(v);
    base = n_lmr; dbase = done_cnt; ebase = err_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    repeat (2 * WAIT + 8) @(negedge clk);
    if (v[26]) begin
      chk("R2 error pulse count", err_cnt - ebase, 1);
      chk("R2 error pulse cycle", err_cyc, acc);
      chk("R2 no load issued", n_lmr - base, 0);
      chk("R2 no done pulse", done_cnt - dbase, 0);
    end else begin
      chk("R6 two loads issued", n_lmr - base, 2);
      chk("R4 ext bank select", log_ba[base], 1);
      chk("R4 ext address", log_addr[base], int'(v[25:13]));
      chk("R3 ext load cycle", log_cyc[base], acc + 1);
      chk("R5 base bank select", log_ba[base + 1], 0);
      chk("R5 base address", log_addr[base + 1], int'(v[12:0]));
      chk("R6 load spacing", log_cyc[base + 1] - log_cyc[base], WAIT + 1);
      chk("R7 done count", done_cnt - dbase, 1);
      chk("R7 done cycle", done_cyc - log_cyc[base + 1], WAIT + 1);
      chk("R2 no error", err_cnt - ebase, 0);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset cmd", int'(cmd_lmr_o), 0);
    chk("R1 reset own bus", int'(own_bus_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset err", int'(err_o), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // directed: hold banks busy, then a burst, then release
    begin
      int base, rel;
      banks_idle = 1'b0;
      offer({4'd4, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 13'h000, 13'h122});
      base = n_lmr;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk("R3 stalled on busy banks", n_lmr - base, 0);
      chk("R1 not ready while pending", int'(req_ready), 0);
      chk("R8 bus not held while stalled", int'(own_bus_o), 0);
      banks_idle = 1'b1;
      burst_active = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 stalled on active burst", n_lmr - base, 0);
      burst_active = 1'b0;
      rel = cyc;
      @(negedge clk);
      chk("R8 bus held at ext load", int'(own_bus_o), 1);
      chk("R1 not ready during load", int'(req_ready), 0);
      repeat (2 * WAIT + 1) @(negedge clk);
      chk("R8 bus held in last quiet cycle", int'(own_bus_o), 1);
      @(negedge clk);
      chk("R7 done visible", int'(done_o), 1);
      chk("R8 bus released at done", int'(own_bus_o), 0);
      @(negedge clk);
      chk("R7 ready after done", int'(req_ready), 1);
      chk("R3 ext load after release", log_cyc[base], rel + 1);
      chk("R5 base address stall case", log_addr[base + 1], 13'h122);
      chk("R4 ext address stall case", log_addr[base], 0);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule